// File: doc/BRIEF.md
# Zero-Address Stack Arithmetic Evaluator

This block evaluates arithmetic written in postfix form. It keeps a small operand stack of its own and takes one command per clock: push an immediate value, add the two topmost values, multiply the two topmost values, or remove the topmost value and present it on an output port. Operands are never named. Every arithmetic command works on the two entries at the top of the stack and leaves a single result in their place.

A host streams a postfix program into the command port. For example, the sequence push 3, push 4, multiply, push 5, push 6, multiply, add leaves 42 on top, with 12 and 30 as the intermediate tops. A final pop hands the result to the host, which writes it to its destination. A command that cannot be carried out sets a sticky error flag and does not change the stack. Such a command is a pop on an empty stack, an add or multiply with fewer than two entries, or a push onto a full stack.

Top module: `rpn_stack_eval`

## Requirements
- R1: A push (opcode 2'b00) with fewer than DEPTH entries on the stack makes cmd_data the new top. One clock later top_data equals cmd_data and stack_count has risen by one.
- R2: An add (opcode 2'b01) with at least two entries replaces the top two entries with their sum, truncated to DATA_W bits. stack_count falls by one.
- R3: A multiply (opcode 2'b10) with at least two entries replaces the top two entries with their product, truncated to DATA_W bits. stack_count falls by one.
- R4: A pop (opcode 2'b11) with at least one entry raises out_valid for exactly one clock, with out_data holding the old top. stack_count falls by one.
- R5: cmd_ready is always high. A cycle with cmd_valid low changes neither the stack nor the error flag, and out_valid is low in the following cycle.
- R6: A push when stack_count equals DEPTH is discarded. The stack and stack_count stay unchanged and err is set.
- R7: An add or multiply with fewer than two entries, or a pop with no entries, sets err and leaves the stack unchanged. Such a pop does not raise out_valid.
- R8: err is sticky. Once set, it stays high until reset, whatever later commands arrive.
- R9: After reset, stack_count is 0, err is 0, out_valid is 0 and top_data is 0.
- R10: top_data shows the top entry whenever stack_count is non-zero, and shows 0 when the stack is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is presented |
| cmd_ready | output | 1 | Always high: one command is accepted per clock |
| cmd_op | input | 2 | 00 push, 01 add, 10 multiply, 11 pop |
| cmd_data | input | DATA_W | Immediate operand for push |
| out_valid | output | 1 | One-clock pulse for a popped value |
| out_data | output | DATA_W | Popped value |
| top_data | output | DATA_W | Current top of stack, 0 when empty |
| stack_count | output | $clog2(DEPTH+1) | Number of entries held |
| err | output | 1 | Sticky illegal-command flag |

## Verification
Each accepted command makes two decisions in the same clock: whether the stack is updated and whether the sticky error is latched. The bench sends illegal commands directly after legal ones and legal commands directly after illegal ones. These include a pop on an empty stack, an add with a single entry, and a push at full depth. A behavioural queue model predicts the count, the top, the error flag and the output pulse, and the bench compares them after every clock. A wrong guard shows up either as a moved stack with the error set, or as a lost result.

// File: rtl/rpn_pkg.sv
package rpn_pkg;
  typedef enum logic [1:0] {
    OP_PUSH = 2'b00,
    OP_ADD  = 2'b01,
    OP_MUL  = 2'b10,
    OP_POP  = 2'b11
  } rpn_op_e;
endpackage

// File: rtl/rpn_stack_mem.sv
module rpn_stack_mem #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_val,
  input  logic [PTR_W-1:0]  top_idx,
  input  logic [PTR_W-1:0]  nxt_idx,
  output logic [DATA_W-1:0] top_val,
  output logic [DATA_W-1:0] nxt_val
);
  logic [DATA_W-1:0] slot [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        slot[g] <= '0;
      else if (wr_en && (wr_idx == PTR_W'(g)))
        slot[g] <= wr_val;
    end
  end

  always_comb begin
    top_val = '0;
    nxt_val = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (top_idx == PTR_W'(i)) top_val = slot[i];
      if (nxt_idx == PTR_W'(i)) nxt_val = slot[i];
    end
  end
endmodule

// File: rtl/rpn_alu.sv
module rpn_alu #(
  parameter int DATA_W = 16
) (
  input  logic              is_mul,
  input  logic [DATA_W-1:0] lhs,
  input  logic [DATA_W-1:0] rhs,
  output logic [DATA_W-1:0] res
);
  function automatic logic [DATA_W-1:0] f_add(input logic [DATA_W-1:0] a,
                                              input logic [DATA_W-1:0] b);
    return a + b;
  endfunction

  function automatic logic [DATA_W-1:0] f_mul(input logic [DATA_W-1:0] a,
                                              input logic [DATA_W-1:0] b);
    return a * b;
  endfunction

  assign res = is_mul ? f_mul(lhs, rhs) : f_add(lhs, rhs);
endmodule

// File: rtl/rpn_ctrl.sv
module rpn_ctrl
  import rpn_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic [DATA_W-1:0] top_val,
  input  logic [DATA_W-1:0] alu_res,
  output logic              alu_is_mul,
  output logic              wr_en,
  output logic [PTR_W-1:0]  wr_idx,
  output logic [DATA_W-1:0] wr_val,
  output logic [PTR_W-1:0]  top_idx,
  output logic [PTR_W-1:0]  nxt_idx,
  output logic [CNT_W-1:0]  count,
  output logic              err,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  rpn_op_e op;
  logic is_push, is_bin, is_pop;
  logic full, has_one, has_two;
  logic push_ok, bin_ok, pop_ok, bad_cmd;

  assign op      = rpn_op_e'(cmd_op);
  assign is_push = cmd_valid && (op == OP_PUSH);
  assign is_bin  = cmd_valid && ((op == OP_ADD) || (op == OP_MUL));
  assign is_pop  = cmd_valid && (op == OP_POP);

  assign full    = (count == CNT_W'(DEPTH));
  assign has_one = (count != '0);
  assign has_two = (count > CNT_W'(1));

  assign push_ok = is_push && !full;
  assign bin_ok  = is_bin && has_two;
  assign pop_ok  = is_pop && has_one;
  assign bad_cmd = (is_push && full) || (is_bin && !has_two) || (is_pop && !has_one);

  assign top_idx    = PTR_W'(count - CNT_W'(1));
  assign nxt_idx    = PTR_W'(count - CNT_W'(2));
  assign alu_is_mul = (op == OP_MUL);

  assign wr_en  = push_ok || bin_ok;
  assign wr_idx = push_ok ? PTR_W'(count) : nxt_idx;
  assign wr_val = push_ok ? cmd_data : alu_res;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count     <= '0;
      err       <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= pop_ok;
      if (pop_ok) out_data <= top_val;
      if (push_ok)              count <= count + CNT_W'(1);
      else if (bin_ok || pop_ok) count <= count - CNT_W'(1);
      if (bad_cmd) err <= 1'b1;
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH)); // R6
  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |=> count == $past(count) + CNT_W'(1)); // R1
  AST_BIN_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
    bin_ok |=> count == $past(count) - CNT_W'(1)); // R2
  AST_POP_EMITS: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok |=> out_valid && (out_data == $past(top_val))); // R4
  AST_BAD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    bad_cmd |=> err && $stable(count) && !out_valid); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(count) && !out_valid); // R5
endmodule

// File: rtl/rpn_stack_eval.sv
module rpn_stack_eval #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [DATA_W-1:0] cmd_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [DATA_W-1:0] top_data,
  output logic [CNT_W-1:0]  stack_count,
  output logic              err
);
  logic              alu_is_mul, wr_en;
  logic [PTR_W-1:0]  wr_idx, top_idx, nxt_idx;
  logic [DATA_W-1:0] wr_val, top_val, nxt_val, alu_res;

  assign cmd_ready = 1'b1;

  rpn_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .top_val(top_val), .alu_res(alu_res),
    .alu_is_mul(alu_is_mul), .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val),
    .top_idx(top_idx), .nxt_idx(nxt_idx), .count(stack_count), .err(err),
    .out_valid(out_valid), .out_data(out_data)
  );

  rpn_stack_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val),
    .top_idx(top_idx), .nxt_idx(nxt_idx), .top_val(top_val), .nxt_val(nxt_val)
  );

  // second entry from the top is the left operand
  rpn_alu #(.DATA_W(DATA_W)) u_alu (
    .is_mul(alu_is_mul), .lhs(nxt_val), .rhs(top_val), .res(alu_res)
  );

  assign top_data = (stack_count != '0) ? top_val : '0;

  AST_EMPTY_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (stack_count == '0) |-> (top_data == '0)); // R10
endmodule

// File: tb/rpn_stack_eval_test.sv
module rpn_stack_eval_test;
  localparam int W = 16;
  localparam int D = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [1:0] cmd_op = 2'b00;
  logic [W-1:0] cmd_data = '0;
  logic out_valid;
  logic [W-1:0] out_data, top_data;
  logic [3:0] stack_count;
  logic err;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [W-1:0] mq[$];
  bit exp_err = 0;
  bit exp_ov = 0;
  logic [W-1:0] exp_od = '0;

  always #5 clk = ~clk;

  rpn_stack_eval #(.DATA_W(W), .DEPTH(D)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_data(cmd_data), .out_valid(out_valid),
    .out_data(out_data), .top_data(top_data), .stack_count(stack_count), .err(err)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    longint et;
    et = (mq.size() > 0) ? longint'(mq[mq.size()-1]) : 0;
    chk(stack_count == 4'(mq.size()), tag, "count", stack_count, mq.size());
    chk(top_data == W'(et), tag, "top", top_data, et);
    chk(err == exp_err, tag, "err", err, exp_err);
    chk(out_valid == exp_ov, tag, "out_valid", out_valid, exp_ov);
    if (exp_ov) chk(out_data == exp_od, tag, "out_data", out_data, exp_od);
    chk(cmd_ready == 1'b1, "R5", "ready", cmd_ready, 1);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cmd_valid = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    mq.delete(); exp_err = 0; exp_ov = 0;
    compare("R9");
  endtask

  // inputs already settled at a falling edge; result read one clock later
  task automatic do_cmd(input logic [1:0] op, input logic [W-1:0] val);
    string tag;
    logic [W-1:0] a, b;
    cmd_valid = 1'b1; cmd_op = op; cmd_data = val;
    exp_ov = 0;
    case (op)
      2'b00: if (mq.size() < D) begin mq.push_back(val); tag = "R1"; end
             else begin exp_err = 1; tag = "R6"; end
      2'b01, 2'b10: if (mq.size() >= 2) begin
               b = mq.pop_back(); a = mq.pop_back();
               if (op == 2'b01) mq.push_back(W'(int'(a) + int'(b)));
               else mq.push_back(W'(longint'(a) * longint'(b)));
               tag = (op == 2'b01) ? "R2" : "R3";
             end else begin exp_err = 1; tag = "R7"; end
      default: if (mq.size() >= 1) begin
               exp_od = mq.pop_back(); exp_ov = 1; tag = "R4";
             end else begin exp_err = 1; tag = "R7"; end
    endcase
    @(negedge clk);
    cmd_valid = 1'b0;
    compare(tag);
  endtask

  task automatic idle(input string tag);
    cmd_valid = 1'b0; cmd_op = 2'b11; exp_ov = 0;
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    do_reset();
    // textbook sequence: 12, 30, then 42 on top
    do_cmd(2'b00, 3); do_cmd(2'b00, 4); do_cmd(2'b10, 0);
    chk(top_data == 12, "R3", "first product", top_data, 12);
    do_cmd(2'b00, 5); do_cmd(2'b00, 6); do_cmd(2'b10, 0);
    chk(top_data == 30, "R3", "second product", top_data, 30);
    do_cmd(2'b01, 0);
    chk(top_data == 42, "R2", "sum", top_data, 42);
    do_cmd(2'b11, 0);
    idle("R5");
    // (A+B)(C+D), POP X
    do_cmd(2'b00, 7); do_cmd(2'b00, 9); do_cmd(2'b01, 0);
    do_cmd(2'b00, 2); do_cmd(2'b00, 11); do_cmd(2'b01, 0);
    do_cmd(2'b10, 0); do_cmd(2'b11, 0);
    // truncation of sum and product
    do_cmd(2'b00, 16'hFFFF); do_cmd(2'b00, 2); do_cmd(2'b01, 0);
    chk(top_data == 1, "R2", "wrapped sum", top_data, 1);
    do_cmd(2'b00, 300); do_cmd(2'b00, 400); do_cmd(2'b10, 0);
    chk(top_data == 16'(120000), "R3", "wrapped product", top_data, 16'(120000));
    // R10 top value tracks with two entries
    do_cmd(2'b11, 0); do_cmd(2'b11, 0);
    // underflow cases, R7, back to back
    do_cmd(2'b11, 0);
    do_cmd(2'b00, 5);
    do_cmd(2'b01, 0);
    do_cmd(2'b10, 0);
    do_cmd(2'b11, 0);
    do_cmd(2'b11, 0);
    idle("R8");
    do_reset();
    // overflow, R6
    for (int i = 0; i < D; i++) do_cmd(2'b00, W'(100 + i));
    do_cmd(2'b00, 16'h5555);
    do_cmd(2'b01, 0);
    do_cmd(2'b00, 16'h1234);
    idle("R8");
    do_reset();
    idle("R9");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule